// File: doc/BRIEF.md
# Serial Baud Clock Generator

This block derives the timing strobes for an asynchronous serial port from the system clock. By default the path has four stages in a row. A power-of-two prescaler comes first. An 8-bit down-counting reload timer counts its ticks. A toggle stage halves the timer underflow rate, so the serial clock level has an even duty. A last divider of 16 or 8 forms the bit timing. An external serial clock pin can take the place of the whole internal path. The pin passes through a synchronizer, and each of its rising edges then counts as one serial-clock period.

Every output except the clock level is a pulse one system clock wide. The block creates no derived clock domain. The serial shifter uses the pulses to qualify its own registers. `sample_tick` is the oversampling strobe. `bit_tick` marks the bit boundaries. `mid_tick` marks the centre of each bit. There is no data stream at the edge of the block, so there is no valid/ready handshake. Every pin is a plain control or timing signal. In internal mode the bit rate is f_clk × (1/prescale) / (2 × (reload+1) × N), where N is 16 or 8.

Top module: `baud_clkgen`

## Requirements
- R1: `psc_code` selects the prescale ratio. Codes 0 to 5 give 2, 4, 8, 16, 32 and 64. With parameter `VARIANT_B`=0, code 6 gives 2048 and code 7 gives 4096. With `VARIANT_B`=1, code 6 gives 128 and code 7 gives 256.
- R2: In internal mode (`ext_src`=0), `sample_tick` pulses once every 2 × ratio × (reload+1) system clocks.
- R3: In internal mode, `sclk_lvl` stays high for ratio × (reload+1) clocks and then low for the same count. Every `sample_tick` falls inside a high phase.
- R4: `bit_tick` pulses together with every 16th `sample_tick` when `half_rate`=0, and with every 8th when `half_rate`=1.
- R5: `mid_tick` pulses together with the `sample_tick` that lies N/2 sample ticks after each `bit_tick`, where N is 16 or 8. It never coincides with `bit_tick`.
- R6: With `ext_src`=1, each rising edge of `ext_clk` produces one `sample_tick` after the two-flop synchronizer. `psc_code`, the prescaler and `reload` then have no effect on the spacing of the ticks.
- R7: A change of `reload` does not disturb the timer period in progress. The new value is first loaded at the next underflow.
- R8: A change of `psc_code`, `half_rate` or `ext_src` restarts the prescaler, the timer, the toggle stage and the sample divider. Reset release does the same. The first `sample_tick` after such a restart comes (reload+1) × ratio + 1 clock cycles after the edge that took the change, counted in falling edges. During the restart cycle all ticks are low.
- R9: While `rst_n` is low, `sample_tick`, `bit_tick`, `mid_tick` and `sclk_lvl` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psc_code | input | 3 | Prescale ratio select code |
| reload | input | 8 | Timer reload value |
| half_rate | input | 1 | 0: divide by 16, 1: divide by 8 |
| ext_src | input | 1 | 1: use external clock pin |
| ext_clk | input | 1 | External serial clock, asynchronous |
| sclk_lvl | output | 1 | Serial clock level, even duty |
| sample_tick | output | 1 | Oversampling strobe |
| bit_tick | output | 1 | Bit boundary strobe |
| mid_tick | output | 1 | Bit centre strobe |

## Verification
The assertions check invariants on every cycle. The prescaler counter stays inside the decoded ratio. Each underflow flips the clock level. Sample ticks land only in high phases, and bit and mid strobes ride on sample ticks without overlapping each other. A restart silences all ticks, and every external-mode tick follows a synchronized rising edge. The assertions cannot show that the spacings are correct. The bench scenarios cover that: the prescale table for every code, the reload sweep, the 16/8 bit intervals and mid offsets, the deferred reload, the restart latency, and the independence of external mode from the internal settings.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic              ext;
    logic              half;
    logic [CODE_W-1:0] code;
  } mode_t;

  // log2 of the prescale ratio for a select code
  function automatic int psc_shift(input logic [CODE_W-1:0] code, input bit variant_b);
    case (code)
      3'd6:    psc_shift = variant_b ? 7 : 11;
      3'd7:    psc_shift = variant_b ? 8 : 12;
      default: psc_shift = int'(code) + 1;
    endcase
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
#(
  parameter bit VARIANT_B = 1'b0,
  parameter int CNT_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   full;
  logic [CNT_W-1:0] ratio_m1;

  assign full     = {{CNT_W{1'b0}}, 1'b1} << psc_shift(code, VARIANT_B);
  assign ratio_m1 = CNT_W'(full - 1'b1);
  assign tick     = run && (cnt == ratio_m1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (run)          cnt <= tick ? '0 : cnt + 1'b1;
  end

  assert_psc_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ratio_m1);
endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer #(
  parameter int RLD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [RLD_W-1:0] reload,
  output logic             lvl,
  output logic             rise
);
  logic [RLD_W-1:0] cnt;
  logic             uf;

  assign uf   = tick && (cnt == '0);
  assign rise = uf && !lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (restart) begin
      cnt <= reload;
      lvl <= 1'b0;
    end else if (tick) begin
      if (uf) begin
        cnt <= reload;
        lvl <= ~lvl;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assert_uf_flips_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (lvl != $past(lvl)));
endmodule

// File: rtl/baud_sample_div.sv
module baud_sample_div #(
  parameter int DIV_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic pulse,
  input  logic half,
  output logic sample_tick,
  output logic bit_tick,
  output logic mid_tick
);
  localparam int SC_W = $clog2(DIV_MAX);

  logic [SC_W-1:0] scnt;
  logic [SC_W-1:0] last;
  logic [SC_W-1:0] mid;

  assign last = half ? SC_W'(DIV_MAX / 2 - 1) : SC_W'(DIV_MAX - 1);
  assign mid  = half ? SC_W'(DIV_MAX / 4 - 1) : SC_W'(DIV_MAX / 2 - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      scnt        <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
      mid_tick    <= 1'b0;
    end else begin
      sample_tick <= pulse;
      bit_tick    <= pulse && (scnt == last);
      mid_tick    <= pulse && (scnt == mid);
      if (pulse) scnt <= (scnt == last) ? '0 : scnt + 1'b1;
    end
  end

  assert_scnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= last);
  assert_bit_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);
  assert_mid_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mid_tick |-> (sample_tick && !bit_tick));
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
  import baud_pkg::*;
#(
  parameter bit VARIANT_B   = 1'b0,
  parameter int PSC_W       = 12,
  parameter int RLD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] psc_code,
  input  logic [RLD_W-1:0]  reload,
  input  logic              half_rate,
  input  logic              ext_src,
  input  logic              ext_clk,
  output logic              sclk_lvl,
  output logic              sample_tick,
  output logic              bit_tick,
  output logic              mid_tick
);
  mode_t                mode_q;
  mode_t                mode_in;
  logic                 started;
  logic                 restart;
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;
  logic                 ptick;
  logic                 t_lvl;
  logic                 t_rise;
  logic                 pulse;

  assign mode_in = '{ext: ext_src, half: half_rate, code: psc_code};
  assign restart = !started || (mode_in != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      started <= 1'b0;
      sync_q  <= '0;
    end else begin
      mode_q  <= mode_in;
      started <= 1'b1;
      sync_q  <= {sync_q[SYNC_STAGES-1:0], ext_clk};
    end
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

  baud_prescaler #(.VARIANT_B(VARIANT_B), .CNT_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .run(!mode_q.ext && !restart), .code(mode_q.code), .tick(ptick)
  );

  baud_reload_timer #(.RLD_W(RLD_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(ptick),
    .reload(reload), .lvl(t_lvl), .rise(t_rise)
  );

  assign pulse    = mode_q.ext ? ext_rise : t_rise;
  assign sclk_lvl = rst_n && (mode_q.ext ? sync_q[SYNC_STAGES-1] : t_lvl);

  baud_sample_div #(.DIV_MAX(16)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pulse(pulse),
    .half(mode_q.half), .sample_tick(sample_tick), .bit_tick(bit_tick),
    .mid_tick(mid_tick)
  );

  assert_sample_in_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.ext && sample_tick) |-> sclk_lvl);
  assert_ext_tick_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.ext && sample_tick) |-> $past(ext_rise));
  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!sample_tick && !bit_tick && !mid_tick));
endmodule

// File: tb/baud_clkgen_bench.sv
module baud_clkgen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] psc_code = 3'd0;
  logic [7:0] reload = 8'd1;
  logic       half_rate = 1'b0;
  logic       ext_src = 1'b0;
  logic       ext_clk = 1'b0;
  logic       ext_on = 1'b0;
  logic       sclk_lvl, sample_tick, bit_tick, mid_tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ext_cnt = 0;

  baud_clkgen u_baud_clkgen (
    .clk(clk), .rst_n(rst_n), .psc_code(psc_code), .reload(reload),
    .half_rate(half_rate), .ext_src(ext_src), .ext_clk(ext_clk),
    .sclk_lvl(sclk_lvl), .sample_tick(sample_tick), .bit_tick(bit_tick),
    .mid_tick(mid_tick)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // external clock: 5 cycles high, 5 low
  always @(negedge clk) begin
    if (ext_on) begin
      if (ext_cnt == 4) begin
        ext_cnt <= 0;
        ext_clk <= ~ext_clk;
      end else ext_cnt <= ext_cnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      1:       pick = bit_tick;
      2:       pick = mid_tick;
      default: pick = sample_tick;
    endcase
  endfunction

  // counts falling edges until the chosen tick is seen high
  task automatic wait_tick(input int which, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n = n + 1;
    end while (!pick(which));
  endtask

  function automatic int ratio_of(input int code);
    case (code)
      6:       ratio_of = 2048;
      7:       ratio_of = 4096;
      default: ratio_of = 2 << code;
    endcase
  endfunction

  initial begin
    int n;
    int hi;
    int lo;
    // R9: outputs quiet in reset
    repeat (5) @(negedge clk);
    check("R9 sample", int'(sample_tick), 0);
    check("R9 bit", int'(bit_tick), 0);
    check("R9 mid", int'(mid_tick), 0);
    check("R9 level", int'(sclk_lvl), 0);
    psc_code = 3'd1;
    reload   = 8'd3;
    rst_n    = 1'b1;
    // R8: latency from reset release
    wait_tick(0, n);
    check("R8 first tick after reset", n, 4 * 4 + 1);

    // R1 and R2: every prescale code
    reload = 8'd1;
    for (int c = 0; c < 8; c++) begin
      psc_code = 3'(c);
      wait_tick(0, n);
      wait_tick(0, n);
      check($sformatf("R1 code %0d period", c), n, 2 * ratio_of(c) * 2);
    end

    // R2: reload sweep at ratio 2
    psc_code = 3'd0;
    for (int r = 0; r < 8; r++) begin
      reload = 8'(r);
      wait_tick(0, n);
      wait_tick(0, n);
      wait_tick(0, n);
      check($sformatf("R2 reload %0d period", r), n, 2 * 2 * (r + 1));
    end

    // R8: restart latency after a code change
    reload   = 8'd3;
    wait_tick(0, n);
    psc_code = 3'd1;
    wait_tick(0, n);
    check("R8 first tick after code change", n, 4 * 4 + 1);

    // R3: duty, ratio 4, reload 2
    reload = 8'd2;
    wait_tick(0, n);
    wait_tick(0, n);
    hi = 0;
    while (sclk_lvl) begin hi = hi + 1; @(negedge clk); end
    lo = 0;
    while (!sclk_lvl) begin lo = lo + 1; @(negedge clk); end
    check("R3 high phase", hi, 12);
    check("R3 low phase", lo, 12);

    // R4 and R5: ratio 2, reload 0 -> sample period 4
    psc_code = 3'd0;
    reload   = 8'd0;
    half_rate = 1'b0;
    wait_tick(1, n);
    wait_tick(1, n);
    check("R4 bit interval /16", n, 64);
    wait_tick(2, n);
    check("R5 bit to mid /16", n, 32);
    wait_tick(1, n);
    check("R5 mid to bit /16", n, 32);
    half_rate = 1'b1;
    wait_tick(1, n);
    wait_tick(1, n);
    check("R4 bit interval /8", n, 32);
    wait_tick(2, n);
    check("R5 bit to mid /8", n, 16);
    wait_tick(1, n);
    check("R5 mid to bit /8", n, 16);

    // R7: reload change deferred, ratio 2
    half_rate = 1'b0;
    reload = 8'd5;
    wait_tick(0, n);
    wait_tick(0, n);
    wait_tick(0, n);
    check("R7 old period", n, 24);
    reload = 8'd2;
    wait_tick(0, n);
    check("R7 transition period", n, 12 + 6);
    wait_tick(0, n);
    check("R7 new period", n, 12);

    // R6: external source
    ext_on  = 1'b1;
    ext_src = 1'b1;
    wait_tick(0, n);
    wait_tick(0, n);
    wait_tick(0, n);
    check("R6 ext period", n, 10);
    reload = 8'd200;
    wait_tick(0, n);
    wait_tick(0, n);
    check("R6 ext period, reload ignored", n, 10);
    half_rate = 1'b1;
    wait_tick(1, n);
    wait_tick(1, n);
    check("R6 ext bit interval /8", n, 80);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule